// File: doc/BRIEF.md
# Keypad Event Queue with Indexed Peek

This block holds key events for a keypad controller in a 16-entry circular buffer. The key-scan side pushes one event per cycle: a 7-bit key code plus a press/release flag. The host side reads bytes in one of two ways. A consuming read moves the head forward first and then returns the entry at the new head. An indexed peek returns the entry a given distance from the head and moves nothing.

Each accepted push raises a one-cycle keypad interrupt request. A push into a full queue is dropped and raises a one-cycle overflow report to the error/status unit. That unit answers with a level, `ovf_latched_i`, which is high while its error flag and its overflow cause are both set. While that level is high, every push is ignored without any report. A configuration write pulses `clear_i`, which empties the queue.

Top module: `keypad_event_fifo`

## Requirements
- R1: Storage has 16 slots. All positions wrap modulo 16, so event order is kept across any number of total pushes when pops keep pace.
- R2: A stored event byte carries the press/release flag in bit 7 and the key code in bits 6:0.
- R3: An accepted push writes its byte at slot (head + count) mod 16, and the count then grows by one.
- R4: A push that arrives while the count is 16 is discarded. `ovf_err_o` is then high for exactly the next cycle, `kp_irq_o` stays low, and the stored contents do not change.
- R5: While `ovf_latched_i` is high, a push is ignored completely: no store, no `kp_irq_o` and no `ovf_err_o`.
- R6: Every accepted push makes `kp_irq_o` high for exactly the next cycle.
- R7: A consuming read with a count of 0 or 1 returns 0x00 and changes nothing. Otherwise the head advances by one mod 16, the count drops by one, and the read returns the entry at the new head. When a consuming read and a peek arrive together, only the consuming read is served.
- R8: A peek with index i returns 0x00 when i is at least the count. Otherwise it returns the entry at (head + i) mod 16. A peek never changes the head or the count.
- R9: `clear_i` sets the head and the count to zero. It overrides any push or read in the same cycle, and such a read returns 0x00.
- R10: When a push and a consuming read arrive in the same cycle, the count becomes count + pushed − popped. The full test uses the count from before that cycle.
- R11: After reset, all outputs are 0. `rd_valid_o` is high in the cycle after each read request, and `rd_data_o` holds the result in that same cycle. When `rd_valid_o` is low, `rd_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Empty the queue (configuration write) |
| push_i | input | 1 | Push one key event |
| push_code_i | input | 7 | Key code of the pushed event |
| push_pressed_i | input | 1 | Press (1) or release (0) of the pushed event |
| ovf_latched_i | input | 1 | Overflow error latched in the error/status unit |
| rd_pop_i | input | 1 | Consuming read request |
| rd_peek_i | input | 1 | Non-destructive indexed read request |
| rd_peek_idx_i | input | 8 | Distance from the head for a peek |
| rd_valid_o | output | 1 | Read result present this cycle |
| rd_data_o | output | 8 | Read result byte |
| kp_irq_o | output | 1 | Keypad interrupt request pulse |
| ovf_err_o | output | 1 | Overflow error pulse |

## Verification
A wrong head pointer or count does not show on the interrupt pins. It shows at the next read: a peek of index 0 or of the last index returns the wrong byte, or returns 0x00 where an event was expected, one cycle after the request. An off-by-one count shows up at the boundaries. A consuming read with one entry returns a non-zero byte, or a push at count 16 gives an interrupt instead of an overflow pulse, in the cycle after that push or read. The bench therefore sweeps every fill level from 0 to 16, peeks every index around the count, and runs long streams of pushes and pops together so that the head wraps several times.

// File: rtl/kef_pkg.sv
package kef_pkg;
  localparam int KEY_CODE_W = 7;
  localparam int EVENT_W    = KEY_CODE_W + 1;

  typedef struct packed {
    logic                  pressed;
    logic [KEY_CODE_W-1:0] code;
  } key_event_t;

  function automatic logic [EVENT_W-1:0] pack_event(input logic [KEY_CODE_W-1:0] code,
                                                    input logic pressed);
    key_event_t ev;
    ev.pressed = pressed;
    ev.code    = code;
    return ev;
  endfunction
endpackage

// File: rtl/kef_ram.sv
module kef_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/kef_ctrl.sv
module kef_ctrl #(
  parameter int DEPTH_LOG2 = 4,
  parameter int IDX_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear_i,
  input  logic                  push_i,
  input  logic                  ovf_latched_i,
  input  logic                  rd_pop_i,
  input  logic                  rd_peek_i,
  input  logic [IDX_W-1:0]      rd_peek_idx_i,
  output logic [DEPTH_LOG2-1:0] head_o,
  output logic [DEPTH_LOG2:0]   count_o,
  output logic                  we_o,
  output logic [DEPTH_LOG2-1:0] waddr_o,
  output logic                  re_o,
  output logic [DEPTH_LOG2-1:0] raddr_o,
  output logic                  rd_req_o,
  output logic                  rd_hit_o,
  output logic                  kp_irq_o,
  output logic                  ovf_err_o
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int CNT_W = DEPTH_LOG2 + 1;

  logic [DEPTH_LOG2-1:0] head_q;
  logic [CNT_W-1:0]      count_q;
  logic                  full;
  logic                  push_live;
  logic                  push_acc;
  logic                  push_ovf;
  logic                  pop_acc;
  logic                  peek_sel;
  logic                  peek_hit;
  logic [IDX_W-1:0]      count_ext;

  assign full      = (count_q == CNT_W'(DEPTH));
  assign push_live = push_i && !ovf_latched_i && !clear_i;
  assign push_acc  = push_live && !full;
  assign push_ovf  = push_live && full;
  assign pop_acc   = rd_pop_i && !clear_i && (count_q > CNT_W'(1));
  assign peek_sel  = rd_peek_i && !rd_pop_i && !clear_i;
  assign count_ext = IDX_W'(count_q);
  assign peek_hit  = peek_sel && (rd_peek_idx_i < count_ext);

  assign we_o     = push_acc;
  assign waddr_o  = head_q + count_q[DEPTH_LOG2-1:0];
  assign raddr_o  = rd_pop_i ? head_q + DEPTH_LOG2'(1)
                             : head_q + rd_peek_idx_i[DEPTH_LOG2-1:0];
  assign re_o     = pop_acc || peek_hit;
  assign rd_req_o = rd_pop_i || rd_peek_i;
  assign rd_hit_o = pop_acc || peek_hit;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_q + DEPTH_LOG2'(pop_acc);
      count_q <= count_q + CNT_W'(push_acc) - CNT_W'(pop_acc);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kp_irq_o  <= 1'b0;
      ovf_err_o <= 1'b0;
    end else begin
      kp_irq_o  <= push_acc;
      ovf_err_o <= push_ovf;
    end
  end

  assign head_o  = head_q;
  assign count_o = count_q;
endmodule

// File: rtl/kef_rdout.sv
module kef_rdout #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req_i,
  input  logic          rd_hit_i,
  input  logic [DW-1:0] ram_q_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  logic vld_q;
  logic zero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      zero_q <= 1'b1;
    end else begin
      vld_q  <= rd_req_i;
      zero_q <= !rd_hit_i;
    end
  end

  assign rd_valid_o = vld_q;
  assign rd_data_o  = zero_q ? '0 : ram_q_i;
endmodule

// File: rtl/keypad_event_fifo.sv
module keypad_event_fifo
  import kef_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4,
  parameter int IDX_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear_i,
  input  logic                  push_i,
  input  logic [KEY_CODE_W-1:0] push_code_i,
  input  logic                  push_pressed_i,
  input  logic                  ovf_latched_i,
  input  logic                  rd_pop_i,
  input  logic                  rd_peek_i,
  input  logic [IDX_W-1:0]      rd_peek_idx_i,
  output logic                  rd_valid_o,
  output logic [EVENT_W-1:0]    rd_data_o,
  output logic                  kp_irq_o,
  output logic                  ovf_err_o
);
  logic [DEPTH_LOG2-1:0] head_w;
  logic [DEPTH_LOG2:0]   count_w;
  logic                  we_w;
  logic                  re_w;
  logic [DEPTH_LOG2-1:0] waddr_w;
  logic [DEPTH_LOG2-1:0] raddr_w;
  logic                  rd_req_w;
  logic                  rd_hit_w;
  logic [EVENT_W-1:0]    wdata_w;
  logic [EVENT_W-1:0]    ram_q_w;

  assign wdata_w = pack_event(push_code_i, push_pressed_i);

  kef_ctrl #(.DEPTH_LOG2(DEPTH_LOG2), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .clear_i(clear_i), .push_i(push_i),
    .ovf_latched_i(ovf_latched_i), .rd_pop_i(rd_pop_i), .rd_peek_i(rd_peek_i),
    .rd_peek_idx_i(rd_peek_idx_i), .head_o(head_w), .count_o(count_w),
    .we_o(we_w), .waddr_o(waddr_w), .re_o(re_w), .raddr_o(raddr_w),
    .rd_req_o(rd_req_w), .rd_hit_o(rd_hit_w), .kp_irq_o(kp_irq_o),
    .ovf_err_o(ovf_err_o)
  );

  kef_ram #(.AW(DEPTH_LOG2), .DW(EVENT_W)) u_ram (
    .clk(clk), .we(we_w), .waddr(waddr_w), .wdata(wdata_w),
    .re(re_w), .raddr(raddr_w), .rdata(ram_q_w)
  );

  kef_rdout #(.DW(EVENT_W)) u_rdout (
    .clk(clk), .rst(rst), .rd_req_i(rd_req_w), .rd_hit_i(rd_hit_w),
    .ram_q_i(ram_q_w), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/kef_chk.sv
module kef_chk #(
  parameter int DEPTH_LOG2 = 4,
  parameter int IDX_W      = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clear_i,
  input logic                  push_i,
  input logic                  ovf_latched_i,
  input logic                  rd_pop_i,
  input logic                  rd_peek_i,
  input logic [IDX_W-1:0]      rd_peek_idx_i,
  input logic [DEPTH_LOG2-1:0] head,
  input logic [DEPTH_LOG2:0]   count,
  input logic                  rd_valid_o,
  input logic [7:0]            rd_data_o,
  input logic                  kp_irq_o,
  input logic                  ovf_err_o
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int CNT_W = DEPTH_LOG2 + 1;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push_i && !ovf_latched_i && !clear_i && count == CNT_W'(DEPTH)
    |=> ovf_err_o && !kp_irq_o); // R4
  AST_SUPPRESSED_PUSH: assert property (@(posedge clk) disable iff (rst)
    ovf_latched_i |=> !kp_irq_o && !ovf_err_o); // R5
  AST_IRQ_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
    push_i && !ovf_latched_i && !clear_i && count < CNT_W'(DEPTH) |=> kp_irq_o); // R6
  AST_SHORT_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_pop_i && count <= CNT_W'(1) |=> rd_data_o == 8'h00 && $stable(head)); // R7
  AST_PEEK_KEEPS_HEAD: assert property (@(posedge clk) disable iff (rst)
    rd_peek_i && !rd_pop_i && !clear_i |=> $stable(head)); // R8
  AST_PEEK_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_peek_i && !rd_pop_i && (rd_peek_idx_i >= IDX_W'(count)) |=> rd_data_o == 8'h00); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> count == '0 && head == '0); // R9
  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    (rd_pop_i || rd_peek_i) |=> rd_valid_o); // R11
endmodule

bind keypad_event_fifo kef_chk #(.DEPTH_LOG2(DEPTH_LOG2), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .clear_i(clear_i), .push_i(push_i),
  .ovf_latched_i(ovf_latched_i), .rd_pop_i(rd_pop_i), .rd_peek_i(rd_peek_i),
  .rd_peek_idx_i(rd_peek_idx_i), .head(head_w), .count(count_w),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .kp_irq_o(kp_irq_o),
  .ovf_err_o(ovf_err_o)
);

// File: tb/keypad_event_fifo_test.sv
module keypad_event_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clear_i = 1'b0;
  logic       push_i = 1'b0;
  logic [6:0] push_code_i = '0;
  logic       push_pressed_i = 1'b0;
  logic       ovf_latched_i = 1'b0;
  logic       rd_pop_i = 1'b0;
  logic       rd_peek_i = 1'b0;
  logic [7:0] rd_peek_idx_i = '0;
  logic       rd_valid_o;
  logic [7:0] rd_data_o;
  logic       kp_irq_o;
  logic       ovf_err_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  logic [7:0] model [16];
  int mhead = 0;
  int mcount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_event_fifo uut (
    .clk(clk), .rst(rst), .clear_i(clear_i), .push_i(push_i),
    .push_code_i(push_code_i), .push_pressed_i(push_pressed_i),
    .ovf_latched_i(ovf_latched_i), .rd_pop_i(rd_pop_i), .rd_peek_i(rd_peek_i),
    .rd_peek_idx_i(rd_peek_idx_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .kp_irq_o(kp_irq_o), .ovf_err_o(ovf_err_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, update the model, then compare at the next falling edge.
  task automatic step(input bit push, input int code, input bit pressed, input bit pop,
                      input bit peek, input int idx, input bit clr, input bit ovl,
                      input string tag);
    int old_count;
    int exp_data;
    bit exp_irq;
    bit exp_ovf;
    bit exp_vld;
    push_i = push; push_code_i = code[6:0]; push_pressed_i = pressed;
    rd_pop_i = pop; rd_peek_i = peek; rd_peek_idx_i = idx[7:0];
    clear_i = clr; ovf_latched_i = ovl;
    exp_vld = pop || peek; exp_data = 0; exp_irq = 0; exp_ovf = 0;
    old_count = mcount;
    if (clr) begin
      mhead = 0; mcount = 0;
    end else begin
      if (push && !ovl) begin
        if (old_count == 16) exp_ovf = 1;
        else begin
          model[(mhead + old_count) % 16] = (pressed ? 8'h80 : 8'h00) | 8'(code % 128);
          exp_irq = 1;
          mcount++;
        end
      end
      if (pop) begin
        if (old_count > 1) begin
          mhead = (mhead + 1) % 16;
          mcount--;
          exp_data = int'(model[mhead]);
        end
      end else if (peek && idx < old_count) begin
        exp_data = int'(model[(mhead + idx) % 16]);
      end
    end
    @(negedge clk);
    check(tag, "rd_valid_o", int'(rd_valid_o), int'(exp_vld));
    check(tag, "rd_data_o", int'(rd_data_o), exp_data);
    check(tag, "kp_irq_o", int'(kp_irq_o), int'(exp_irq));
    check(tag, "ovf_err_o", int'(ovf_err_o), int'(exp_ovf));
    push_i = 0; rd_pop_i = 0; rd_peek_i = 0; clear_i = 0; ovf_latched_i = 0;
  endtask

  task automatic peek_sweep(input int upto, input string tag);
    for (int i = 0; i <= upto; i++) step(0, 0, 0, 0, 1, i, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset state
    check("R11", "rd_valid_o after reset", int'(rd_valid_o), 0);
    check("R11", "rd_data_o after reset", int'(rd_data_o), 0);
    check("R11", "kp_irq_o after reset", int'(kp_irq_o), 0);
    check("R11", "ovf_err_o after reset", int'(ovf_err_o), 0);

    step(0, 0, 0, 1, 0, 0, 0, 0, "R7");          // pop on empty
    step(0, 0, 0, 0, 1, 0, 0, 0, "R8");          // peek on empty
    step(1, 7'h3c, 1, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R2");          // peek must give 0xbc
    check("R2", "format of code 0x3c pressed", int'(rd_data_o), 8'hbc);
    step(0, 0, 0, 1, 0, 0, 0, 0, "R7");          // count 1: pop gives 0
    step(0, 0, 0, 0, 1, 0, 0, 0, "R7");          // entry still there

    step(0, 0, 0, 0, 0, 0, 1, 0, "R9");
    for (int k = 0; k < 16; k++) step(1, k * 5 + 1, k[0], 0, 0, 0, 0, 0, "R3");
    peek_sweep(19, "R8");
    step(1, 7'h55, 1, 0, 0, 0, 0, 0, "R4");      // full: dropped, overflow pulse
    peek_sweep(16, "R4");
    step(1, 7'h22, 0, 0, 0, 0, 0, 1, "R5");      // latched overflow: ignored
    step(1, 7'h23, 1, 0, 1, 15, 0, 1, "R5");
    step(1, 7'h24, 0, 1, 0, 0, 0, 0, "R10");     // full with pop: push rejected
    peek_sweep(16, "R10");
    for (int k = 0; k < 17; k++) step(0, 0, 0, 1, 0, 0, 0, 0, "R7");
    for (int k = 0; k < 40; k++) begin
      step(1, k + 40, ~k[1], 1, 0, 0, 0, 0, "R1");
      if (k % 8 == 7) peek_sweep(3, "R1");
    end
    for (int k = 0; k < 20; k++) step(1, k + 90, k[0], 0, 0, 0, 0, 0, "R1");
    peek_sweep(17, "R1");
    step(0, 0, 0, 1, 1, 3, 0, 0, "R7");          // pop wins over peek
    step(1, 7'h11, 1, 1, 1, 0, 1, 0, "R9");      // clear overrides all
    step(0, 0, 0, 0, 1, 0, 0, 0, "R9");

    // Near-exhaustive: every fill level, every peek index around it, then pops.
    for (int lvl = 0; lvl <= 16; lvl++) begin
      step(0, 0, 0, 0, 0, 0, 1, 0, "R9");
      for (int k = 0; k < lvl; k++) step(1, (lvl * 7 + k * 3) % 128, k[1], 0, 0, 0, 0, 0, "R3");
      peek_sweep(lvl + 1, "R8");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R7");
      step(1, lvl, 1, 1, 0, 0, 0, 0, "R10");
      peek_sweep(lvl + 1, "R8");
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule